// File: doc/BRIEF.md
# Quad-IO Protection Register Slave

This block is the protection-register slave of a serial memory device. A host reaches it over a 4-bit bidirectional data bus, qualified by an active-low select and a serial clock. The block keeps an 80-bit protection vector and presents it as a parallel output for the surrounding logic. It answers two operations, each opened by a one-byte opcode. The read operation streams the vector out. The write operation replaces the vector.

Every byte on the bus occupies two serial clock cycles, upper nibble first. The slave samples inputs on the rising serial clock edge and launches outputs on the falling edge. The vector moves from bit 79 down to bit 0.

The block runs on a fast fabric clock `clk`. The serial clock, the select and the data inputs pass through a synchroniser chain of `SYNC_STAGES` flops and are then edge-detected. The output nibble becomes valid at most `SYNC_STAGES`+1 `clk` cycles after a falling serial clock edge. Each serial clock phase must last at least `SYNC_STAGES`+2 `clk` cycles. The serial clock must not toggle in the `clk` cycle in which select falls. The data pins are split into `dq_in`, `dq_out` and `dq_oe`, and a pad-level tri-state buffer combines them outside the block.

Top module: `qio_prot_reg`

## Requirements
- R1: A synchronous active-high `rst` sets `prot_bits` to all ones, drives `dq_oe` low and returns the decoder to waiting for an opcode at the next select-low.
- R2: The first two nibbles after `sel_n` falls form the opcode, upper nibble first, sampled on rising `sclk`. Opcode 0x72 selects a read and 0x42 selects a write.
- R3: After a read opcode, each falling `sclk` edge presents the next nibble on `dq_out` with `dq_oe` high. The first nibble is bits 79:76, the next is 75:72, and so on down to 3:0, 20 nibbles in all.
- R4: After the 20th nibble a read does not wrap. Every further falling edge presents 0x0 until `sel_n` goes high.
- R5: After a write opcode, nibbles are sampled on rising `sclk`. The first nibble lands in bits 79:76 and the 20th in bits 3:0. `prot_bits` takes the new value only when `sel_n` rises after exactly 20 data nibbles.
- R6: A write that ends with fewer or more than 20 data nibbles leaves `prot_bits` unchanged.
- R7: Any opcode other than 0x72 or 0x42 makes the rest of the transaction ignored. `dq_oe` stays low, `prot_bits` is unchanged, and the next transaction decodes normally.
- R8: `dq_oe` is high only during the output phase of a read. It is low again within `SYNC_STAGES`+2 `clk` cycles of `sel_n` rising, and it stays low throughout opcode and write phases.
- R9: A rising `sel_n` ends any transaction at any point, and the next falling `sel_n` starts with a fresh opcode.
- R10: Transactions work whether `sclk` idles low or high while `sel_n` is high (clock modes 0 and 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low transaction select |
| dq_in | input | 4 | Data nibble from the bus |
| dq_out | output | 4 | Data nibble to the bus |
| dq_oe | output | 1 | Drive enable for the data pins |
| prot_bits | output | 80 | Current protection vector |

## Verification
The bound checker watches the following on every cycle:
- the reset state;
- that the drive enable is only ever high in the read phase, and drops within the stated window after select rises;
- that only zero nibbles appear once the vector is exhausted;
- that a rejected opcode can never lead into a read or a write;
- that the vector changes only while select is high.

The bench scenarios show the properties that depend on data and on counting transaction length:
- that each streamed nibble matches its bit slice;
- that a written value lands in the right positions;
- that a short write or an overlong write is discarded;
- that a transaction aborted mid-read leaves the next one clean;
- that both clock idle levels decode alike.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_SKIP  = 3'd4
  } qpr_state_e;

  localparam logic [7:0] OPC_READ_DEF  = 8'h72;
  localparam logic [7:0] OPC_WRITE_DEF = 8'h42;
endpackage

// File: rtl/qpr_sync.sv
module qpr_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpr_ctrl.sv
module qpr_ctrl
  import qpr_pkg::*;
#(
  parameter int         REG_BITS = 80,
  parameter int         NIB_W    = 4,
  parameter int         CMD_W    = 8,
  parameter logic [7:0] OPC_READ  = OPC_READ_DEF,
  parameter logic [7:0] OPC_WRITE = OPC_WRITE_DEF
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    sclk_s,
  input  logic                                    sel_n_s,
  input  logic [NIB_W-1:0]                        dq_s,
  output qpr_state_e                              state_o,
  output logic [$clog2(REG_BITS/NIB_W+2)-1:0]     nib_cnt_o,
  output logic                                    load_o,
  output logic                                    step_o,
  output logic                                    commit_o,
  output logic [REG_BITS-1:0]                     shadow_o
);
  localparam int NIBBLES  = REG_BITS / NIB_W;
  localparam int CNT_W    = $clog2(NIBBLES + 2);
  localparam int CMD_NIBS = CMD_W / NIB_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NIBBLES);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NIBBLES + 1);
  localparam logic [CNT_W-1:0] CNT_OPC  = CNT_W'(CMD_NIBS - 1);

  qpr_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [REG_BITS-1:0] shadow_q;
  logic                sclk_d, sel_d;
  logic                rise, fall, sel_rise;
  logic [CMD_W-1:0]    opc_full;
  logic                opc_last;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign sel_rise = sel_n_s & ~sel_d;
  assign opc_full = {cmd_q[CMD_W-NIB_W-1:0], dq_s};
  assign opc_last = (state_q == ST_CMD) && rise && (cnt_q == CNT_OPC);

  // Edge history registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_n_s;
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= '0;
      shadow_q <= '0;
    end else if (sel_n_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_CMD;
          cnt_q   <= '0;
        end
        ST_CMD: begin
          if (rise) begin
            cmd_q <= opc_full;
            if (opc_last) begin
              cnt_q <= '0;
              if (opc_full == OPC_READ)       state_q <= ST_READ;
              else if (opc_full == OPC_WRITE) state_q <= ST_WRITE;
              else                            state_q <= ST_SKIP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (fall && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        ST_WRITE: begin
          if (rise) begin
            shadow_q <= {shadow_q[REG_BITS-NIB_W-1:0], dq_s};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_SKIP;
        end
      endcase
    end
  end

  assign load_o    = opc_last && (opc_full == OPC_READ) && !sel_n_s;
  assign step_o    = fall && (state_q == ST_READ) && !sel_n_s;
  assign commit_o  = sel_rise && (state_q == ST_WRITE) && (cnt_q == CNT_FULL);
  assign shadow_o  = shadow_q;
  assign state_o   = state_q;
  assign nib_cnt_o = cnt_q;
endmodule

// File: rtl/qpr_rdshift.sv
module qpr_rdshift #(
  parameter int REG_BITS = 80,
  parameter int NIB_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                step,
  input  logic                release_i,
  input  logic [REG_BITS-1:0] src,
  output logic [NIB_W-1:0]    dq_o,
  output logic                oe_o
);
  logic [REG_BITS-1:0] sh_q;

  // Zeros enter from the bottom, so the stream pads itself once drained.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      dq_o <= '0;
      oe_o <= 1'b0;
    end else begin
      if (load) begin
        sh_q <= src;
      end else if (step) begin
        dq_o <= sh_q[REG_BITS-1 -: NIB_W];
        sh_q <= {sh_q[REG_BITS-NIB_W-1:0], {NIB_W{1'b0}}};
      end
      if (release_i)  oe_o <= 1'b0;
      else if (step)  oe_o <= 1'b1;
    end
  end
endmodule

// File: rtl/qpr_store.sv
module qpr_store #(
  parameter int REG_BITS = 80
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic [REG_BITS-1:0] wdata,
  output logic [REG_BITS-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)         value <= '1;
    else if (commit) value <= wdata;
  end
endmodule

// File: rtl/qio_prot_reg.sv
module qio_prot_reg
  import qpr_pkg::*;
#(
  parameter int         REG_BITS    = 80,
  parameter int         NIB_W       = 4,
  parameter int         CMD_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPC_READ    = OPC_READ_DEF,
  parameter logic [7:0] OPC_WRITE   = OPC_WRITE_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                sel_n,
  input  logic [NIB_W-1:0]    dq_in,
  output logic [NIB_W-1:0]    dq_out,
  output logic                dq_oe,
  output logic [REG_BITS-1:0] prot_bits
);
  localparam int NIBBLES = REG_BITS / NIB_W;
  localparam int CNT_W   = $clog2(NIBBLES + 2);
  localparam int SYN_W   = NIB_W + 2;

  logic [SYN_W-1:0]    syn_d, syn_q;
  logic                sclk_s, sel_n_s;
  logic [NIB_W-1:0]    dq_s;
  qpr_state_e          state;
  logic [CNT_W-1:0]    nib_cnt;
  logic                load, step, commit;
  logic [REG_BITS-1:0] shadow;

  assign syn_d = {sel_n, sclk, dq_in};

  qpr_sync #(
    .WIDTH  (SYN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, {(SYN_W-1){1'b0}}})
  ) u_sync (
    .clk(clk), .rst(rst), .d(syn_d), .q(syn_q)
  );

  assign sel_n_s = syn_q[SYN_W-1];
  assign sclk_s  = syn_q[SYN_W-2];
  assign dq_s    = syn_q[NIB_W-1:0];

  qpr_ctrl #(
    .REG_BITS(REG_BITS), .NIB_W(NIB_W), .CMD_W(CMD_W),
    .OPC_READ(OPC_READ), .OPC_WRITE(OPC_WRITE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sel_n_s(sel_n_s), .dq_s(dq_s),
    .state_o(state), .nib_cnt_o(nib_cnt), .load_o(load), .step_o(step),
    .commit_o(commit), .shadow_o(shadow)
  );

  qpr_rdshift #(.REG_BITS(REG_BITS), .NIB_W(NIB_W)) u_rd (
    .clk(clk), .rst(rst), .load(load), .step(step), .release_i(sel_n_s),
    .src(prot_bits), .dq_o(dq_out), .oe_o(dq_oe)
  );

  qpr_store #(.REG_BITS(REG_BITS)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .wdata(shadow), .value(prot_bits)
  );
endmodule

// File: rtl/qpr_checker.sv
module qpr_checker
  import qpr_pkg::*;
#(
  parameter int REG_BITS    = 80,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                sel_n,
  input logic [NIB_W-1:0]                    dq_out,
  input logic                                dq_oe,
  input logic [REG_BITS-1:0]                 prot_bits,
  input qpr_state_e                          state,
  input logic [$clog2(REG_BITS/NIB_W+2)-1:0] nib_cnt
);
  localparam int CNT_W = $clog2(REG_BITS/NIB_W + 2);
  localparam logic [CNT_W-1:0] PAST_END = CNT_W'(REG_BITS/NIB_W + 1);
  localparam logic [7:0] REL_LIM = 8'(SYNC_STAGES + 2);

  logic [7:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !sel_n)      hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prot_bits == '1 && !dq_oe && state == ST_IDLE)); // R1
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (state == ST_READ)); // R8
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sel_n && hi_cnt >= REL_LIM) |-> !dq_oe); // R8
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && state == ST_READ && nib_cnt == PAST_END) |-> (dq_out == '0)); // R4
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |=> (state == ST_SKIP || state == ST_IDLE)); // R7
  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_bits) |-> sel_n); // R5
endmodule

bind qio_prot_reg qpr_checker #(
  .REG_BITS(REG_BITS), .NIB_W(NIB_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .dq_out(dq_out), .dq_oe(dq_oe),
  .prot_bits(prot_bits), .state(state), .nib_cnt(nib_cnt)
);

// File: tb/qio_prot_reg_test.sv
module qio_prot_reg_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        sel_n = 1'b1;
  logic [3:0]  dq_in = '0;
  logic [3:0]  dq_out;
  logic        dq_oe;
  logic [79:0] prot_bits;

  int n_chk = 0;
  int n_fail = 0;
  bit mode3 = 1'b0;
  logic [79:0] exp_reg;

  always #4 clk = ~clk;

  qio_prot_reg uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sel_n(sel_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .prot_bits(prot_bits)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(input logic [79:0] v, input int idx);
    if (idx < 20) return v[79 - 4*idx -: 4];
    return 4'h0;
  endfunction

  task automatic begin_txn();
    sclk = mode3;
    tick(2);
    sel_n = 1'b0;
    tick(HALF);
  endtask

  task automatic end_txn();
    sclk = mode3;
    tick(1);
    sel_n = 1'b1;
    tick(HALF);
    check("R8 oe released", {79'b0, dq_oe}, 80'd0);
    tick(HALF);
  endtask

  task automatic put_nib(input logic [3:0] n);
    sclk = 1'b0;
    dq_in = n;
    tick(HALF);
    check("R8 oe low while host drives", {79'b0, dq_oe}, 80'd0);
    sclk = 1'b1;
    tick(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b);
    put_nib(b[7:4]);
    put_nib(b[3:0]);
  endtask

  task automatic do_read(input int nn);
    begin_txn();
    put_byte(8'h72);
    for (int i = 0; i < nn; i++) begin
      sclk = 1'b0;
      tick(HALF);
      check((i == 0) ? "R2,R3 first nibble" : (i < 20) ? "R3 nibble" : "R4 pad",
            {76'b0, dq_out}, {76'b0, exp_nib(exp_reg, i)});
      check("R3 oe high", {79'b0, dq_oe}, 80'd1);
      sclk = 1'b1;
      tick(HALF);
    end
    end_txn();
  endtask

  task automatic do_write(input logic [79:0] v, input int nn);
    begin_txn();
    put_byte(8'h42);
    for (int i = 0; i < nn; i++) put_nib(exp_nib(v, i) ^ ((i >= 20) ? 4'($urandom) : 4'h0));
    end_txn();
    if (nn == 20) exp_reg = v;
    check((nn == 20) ? "R5 commit" : "R6 length mismatch", prot_bits, exp_reg);
  endtask

  task automatic do_bad(input logic [7:0] opc);
    begin_txn();
    put_byte(opc);
    for (int i = 0; i < 20; i++) put_nib(4'($urandom));
    end_txn();
    check("R7 ignored opcode", prot_bits, exp_reg);
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom, $urandom, 16'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    rst = 1'b0;
    tick(2);
    exp_reg = '1;
    // R1: reset state
    check("R1 reset vector", prot_bits, {80{1'b1}});
    check("R1 reset oe", {79'b0, dq_oe}, 80'd0);
    do_read(20);
    // R5 / R4: write then read past the end
    do_write(80'h0123_4567_89AB_CDEF_FEDC, 20);
    do_read(24);
    // R6: short and long writes
    do_write(80'hAAAA_5555_AAAA_5555_AAAA, 19);
    do_write(80'h1111_2222_3333_4444_5555, 21);
    do_read(20);
    // R7: unknown opcode then normal traffic
    do_bad(8'h27);
    do_bad(8'h43);
    do_read(20);
    // R9: abort read midway, then a clean read
    begin_txn();
    put_byte(8'h72);
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b0; tick(HALF); sclk = 1'b1; tick(HALF);
    end
    end_txn();
    check("R9 abort leaves vector", prot_bits, exp_reg);
    do_read(21);
    // R10: clock idle high
    mode3 = 1'b1;
    do_write(80'hF0E1_D2C3_B4A5_9687_7869, 20);
    do_read(22);
    // Random mix
    for (int k = 0; k < 30; k++) begin
      mode3 = 1'($urandom);
      if (($urandom % 6) == 0) begin
        logic [7:0] opc;
        opc = 8'($urandom);
        if (opc == 8'h72 || opc == 8'h42) opc = 8'h00;
        do_bad(opc);
      end else begin
        do_write(rnd80(), 18 + int'($urandom % 5));
      end
      do_read(20 + int'($urandom % 4));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule